// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches banks of up to 32 external lines each and turns chosen edges on them into interrupt requests and short event pulses. Every line is brought into the clock domain by a two-stage synchronizer. A third stage holds the previous synchronized level, and comparing the two gives the edges. Each line has its own rising-edge enable and its own falling-edge enable, so it can react to either edge or to both. A chosen edge on a line whose interrupt enable is set latches a pending bit. The pending bits of a bank are ORed into that bank's level interrupt output. Software clears pending bits by writing ones to them. The same chosen edge also gives a one-cycle pulse on that line's event output when the line's event enable is set, and the pending state plays no part in this.

Software reaches the block through a plain word-wide register port: an address, a write strobe, a read strobe and data. Software can also raise a line's pending bit itself through the software-trigger register. Two address layouts can be built. The flat layout serves a single bank. The split layout serves up to three banks, with the trigger registers in a lower address region and the enable and pending registers in an upper region. Lines above the implemented count have no storage and read as zero, so software can find the line count by writing all ones and reading the value back. The soft reset clears only the dynamic state. Enables and edge selects keep their values.

Top module: `exti_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it rises, all pending bits, all software-trigger bits, `irq_out` and `evt_out` are 0. The interrupt-enable, event-enable, rising-select and falling-select registers keep the last values written to them across a soft reset, and they can be written while reset is asserted.
- R2: Line n of bank b is `ext_lines[b*32+n]` and bit n of every register of bank b. A rising-select bit of 1 catches only 0-to-1 transitions of its line. A falling-select bit of 1 catches only 1-to-0 transitions. With both set, either transition is caught, and with neither set, none is. A transition that is driven between two clock edges shows in the pending bit and the event bit after the third rising clock edge.
- R3: An interrupt-enable bit of 1 lets its line set its pending bit. While the bit is 0, neither an edge nor a software trigger sets that pending bit.
- R4: Writing a 1 to a pending bit clears it, and writing a 0 leaves it unchanged. When a caught edge and a clear of the same bit occur in the same cycle, the bit stays set.
- R5: `irq_out[b]` is high exactly while at least one pending bit of bank b is set. Pending bits in other banks have no effect on it.
- R6: A caught edge on a line whose event-enable bit is 1 drives that line's `evt_out` bit high for exactly one cycle. This happens whatever the state of the interrupt-enable bit and the pending bit.
- R7: Writing a 1 to a software-trigger bit stores it, and if the line's interrupt-enable bit is 1 it also sets the pending bit. Writing a 0 has no effect. A stored software-trigger bit reads back as 1 until a 1 is written to the pending bit of the same line, which clears both bits.
- R8: Register bits of lines at or above `LINES_IMPL` read as 0 and ignore writes. Writing all ones to a rising-select register and reading it back returns a mask of the implemented lines.
- R9: Flat layout (`MAP_SPLIT`=0, one bank): 0x00 interrupt enable, 0x04 event enable, 0x08 rising select, 0x0C falling select, 0x10 software trigger, 0x14 pending. Split layout (`MAP_SPLIT`=1): rising select, falling select and software trigger are at 0x00/0x04/0x08 plus 0x20 times the bank. Interrupt enable, event enable and pending are at 0x80/0x84/0x88 plus 0x10 times the bank. Reads of unmapped, misaligned or absent-bank addresses return 0, and writes to them change nothing. `bus_rdata` is 0 while `bus_rd` is low.
- R10: A line that is already high when reset ends gives no edge. The synchronizer stages get valid data only after three clock edges, and edges are ignored until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low soft reset of dynamic state |
| ext_lines | input | NUM_BANKS*32 | Asynchronous external lines |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, takes effect at the rising clock edge |
| bus_rd | input | 1 | Read strobe, combinational read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when not reading a mapped register |
| irq_out | output | NUM_BANKS | Level interrupt, one per bank |
| evt_out | output | NUM_BANKS*32 | One-cycle event pulse, one per line |

## Verification
The one-cycle event check assumes that each external line holds its level for at least two clock cycles. Pulses narrower than that could produce caught edges on the same line in two cycles in a row. The bench holds every line level for many cycles between changes. It writes all enable and select registers while reset is still asserted, because those registers have no reset value. The coincident set-and-clear case is timed so that the clear write lands on the same clock edge as the synchronized edge.

// File: rtl/exti_pkg.sv
package exti_pkg;

   localparam int unsigned LINES_PER_BANK = 32;
   localparam int unsigned MAX_BANKS      = 3;
   localparam int unsigned ADDR_W         = 8;
   localparam int unsigned DATA_W         = 32;

   typedef enum logic [2:0] {
      RK_NONE,
      RK_IEN,
      RK_EEN,
      RK_RISE,
      RK_FALL,
      RK_SWT,
      RK_PEND
   } reg_kind_e;

   function automatic logic [DATA_W-1:0] impl_mask(input int unsigned n);
      logic [DATA_W:0] one;
      one = (DATA_W+1)'(1) << n;
      return DATA_W'(one - (DATA_W+1)'(1));
   endfunction

endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lines_i,
   output logic [W-1:0] lvl_now_o,
   output logic [W-1:0] lvl_prev_o,
   output logic         ready_o
);
   logic [W-1:0] stg1_q, stg2_q, stg3_q;
   logic [1:0]   warm_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg1_q <= '0;
         stg2_q <= '0;
         stg3_q <= '0;
         warm_q <= '0;
      end else begin
         stg1_q <= lines_i;
         stg2_q <= stg1_q;
         stg3_q <= stg2_q;
         if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
      end
   end

   assign lvl_now_o  = stg2_q;
   assign lvl_prev_o = stg3_q;
   // all three stages hold sampled data only after the third edge (R10)
   assign ready_o    = (warm_q == 2'd3);
endmodule

// File: rtl/exti_decode.sv
module exti_decode
   import exti_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 1,
   parameter bit          MAP_SPLIT = 1'b0
) (
   input  logic [ADDR_W-1:0] addr_i,
   output reg_kind_e         kind_o,
   output logic [1:0]        bank_o
);
   if (MAP_SPLIT) begin : g_split
      always_comb begin
         kind_o = RK_NONE;
         bank_o = 2'd0;
         if (addr_i[1:0] == 2'b00) begin
            if (!addr_i[7]) begin
               bank_o = addr_i[6:5];
               case (addr_i[4:2])
                  3'd0:    kind_o = RK_RISE;
                  3'd1:    kind_o = RK_FALL;
                  3'd2:    kind_o = RK_SWT;
                  default: kind_o = RK_NONE;
               endcase
            end else if (!addr_i[6]) begin
               bank_o = addr_i[5:4];
               case (addr_i[3:2])
                  2'd0:    kind_o = RK_IEN;
                  2'd1:    kind_o = RK_EEN;
                  2'd2:    kind_o = RK_PEND;
                  default: kind_o = RK_NONE;
               endcase
            end
         end
         if ({30'd0, bank_o} >= NUM_BANKS) kind_o = RK_NONE;
      end
   end else begin : g_flat
      always_comb begin
         bank_o = 2'd0;
         case (addr_i)
            8'h00:   kind_o = RK_IEN;
            8'h04:   kind_o = RK_EEN;
            8'h08:   kind_o = RK_RISE;
            8'h0C:   kind_o = RK_FALL;
            8'h10:   kind_o = RK_SWT;
            8'h14:   kind_o = RK_PEND;
            default: kind_o = RK_NONE;
         endcase
      end
   end
endmodule

// File: rtl/exti_bank.sv
module exti_bank
   import exti_pkg::*;
#(
   parameter int unsigned LINES_IMPL = LINES_PER_BANK
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [LINES_PER_BANK-1:0] lvl_now_i,
   input  logic [LINES_PER_BANK-1:0] lvl_prev_i,
   input  logic                      ready_i,
   input  logic                      wr_en_i,
   input  reg_kind_e                 kind_i,
   input  logic [DATA_W-1:0]         wdata_i,
   output logic [DATA_W-1:0]         rd_word_o,
   output logic                      irq_o,
   output logic [LINES_PER_BANK-1:0] evt_o
);
   localparam logic [DATA_W-1:0] IMPL = impl_mask(LINES_IMPL);

   logic [DATA_W-1:0] ien_q, een_q, rise_q, fall_q;
   logic [DATA_W-1:0] swt_q, pend_q, evt_q;
   logic [DATA_W-1:0] wmask, sw_wr, clr, caught, set_v;

   assign wmask = wdata_i & IMPL;

   // configuration keeps its contents through the soft reset (R1)
   always_ff @(posedge clk) begin
      if (wr_en_i) begin
         case (kind_i)
            RK_IEN:  ien_q  <= wmask;
            RK_EEN:  een_q  <= wmask;
            RK_RISE: rise_q <= wmask;
            RK_FALL: fall_q <= wmask;
            default: ;
         endcase
      end
   end

   assign sw_wr  = (wr_en_i && kind_i == RK_SWT)  ? wmask : '0;
   assign clr    = (wr_en_i && kind_i == RK_PEND) ? wmask : '0;
   assign caught = ((lvl_now_i & ~lvl_prev_i & rise_q) |
                    (~lvl_now_i & lvl_prev_i & fall_q)) &
                   {DATA_W{ready_i}} & IMPL;
   assign set_v  = (caught | sw_wr) & ien_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         swt_q  <= '0;
         evt_q  <= '0;
      end else begin
         pend_q <= (pend_q & ~clr) | set_v;
         swt_q  <= (swt_q | sw_wr) & ~clr;
         evt_q  <= caught & een_q;
      end
   end

   always_comb begin
      case (kind_i)
         RK_IEN:  rd_word_o = ien_q;
         RK_EEN:  rd_word_o = een_q;
         RK_RISE: rd_word_o = rise_q;
         RK_FALL: rd_word_o = fall_q;
         RK_SWT:  rd_word_o = swt_q;
         RK_PEND: rd_word_o = pend_q;
         default: rd_word_o = '0;
      endcase
      rd_word_o = rd_word_o & IMPL;
   end

   assign irq_o = |pend_q;
   assign evt_o = evt_q;

   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(pend_q) & ~$past(clr)) & ~pend_q) == '0)); // R4
   AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(ien_q)) == '0)); // R3
   AST_EVT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((evt_q & ~$past(een_q)) == '0)); // R6
   AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((evt_q & $past(evt_q)) == '0)); // R6
   AST_IRQ_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(|clr)); // R5
endmodule

// File: rtl/exti_ctrl.sv
module exti_ctrl
   import exti_pkg::*;
#(
   parameter int unsigned NUM_BANKS  = 1,
   parameter int unsigned LINES_IMPL = 32,
   parameter bit          MAP_SPLIT  = 1'b0
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_BANKS*LINES_PER_BANK-1:0] ext_lines,
   input  logic [ADDR_W-1:0]                   bus_addr,
   input  logic                                bus_wr,
   input  logic                                bus_rd,
   input  logic [DATA_W-1:0]                   bus_wdata,
   output logic [DATA_W-1:0]                   bus_rdata,
   output logic [NUM_BANKS-1:0]                irq_out,
   output logic [NUM_BANKS*LINES_PER_BANK-1:0] evt_out
);
   localparam int unsigned TOTAL_LINES = NUM_BANKS * LINES_PER_BANK;

   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("exti_ctrl: NUM_BANKS must be 1 to 3");
   end
   if (LINES_IMPL < 1 || LINES_IMPL > LINES_PER_BANK) begin : g_bad_lines
      $error("exti_ctrl: LINES_IMPL must be 1 to 32");
   end
   if (!MAP_SPLIT && NUM_BANKS != 1) begin : g_bad_map
      $error("exti_ctrl: flat layout serves one bank only");
   end

   logic [TOTAL_LINES-1:0] lvl_now, lvl_prev;
   logic                   ready;
   reg_kind_e              kind;
   logic [1:0]             bank;
   logic                   hit;
   logic [DATA_W-1:0]      words [NUM_BANKS];

   exti_sync #(.W(TOTAL_LINES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .lines_i    (ext_lines),
      .lvl_now_o  (lvl_now),
      .lvl_prev_o (lvl_prev),
      .ready_o    (ready)
   );

   exti_decode #(.NUM_BANKS(NUM_BANKS), .MAP_SPLIT(MAP_SPLIT)) u_dec (
      .addr_i (bus_addr),
      .kind_o (kind),
      .bank_o (bank)
   );

   assign hit = (kind != RK_NONE);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      exti_bank #(.LINES_IMPL(LINES_IMPL)) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .lvl_now_i  (lvl_now[b*LINES_PER_BANK +: LINES_PER_BANK]),
         .lvl_prev_i (lvl_prev[b*LINES_PER_BANK +: LINES_PER_BANK]),
         .ready_i    (ready),
         .wr_en_i    (bus_wr && hit && (bank == 2'(b))),
         .kind_i     (kind),
         .wdata_i    (bus_wdata),
         .rd_word_o  (words[b]),
         .irq_o      (irq_out[b]),
         .evt_o      (evt_out[b*LINES_PER_BANK +: LINES_PER_BANK])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd && hit) begin
         for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank == 2'(b)) bus_rdata = words[b];
         end
      end
   end
endmodule

// File: tb/tb_exti_ctrl.sv
module tb_exti_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] ext = '0;
   logic [7:0]  addr = '0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [31:0] wdata = '0, rdata;
   logic [1:0]  irq;
   logic [63:0] evt;

   logic [31:0] fext = '0;
   logic [7:0]  faddr = '0;
   logic        fwr = 1'b0, frd = 1'b0;
   logic [31:0] fwdata = '0, frdata;
   logic [0:0]  firq;
   logic [31:0] fevt;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [31:0] d;

   always #5 clk = ~clk;

   exti_ctrl #(.NUM_BANKS(2), .LINES_IMPL(24), .MAP_SPLIT(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .ext_lines(ext), .bus_addr(addr), .bus_wr(wr),
      .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq), .evt_out(evt));

   exti_ctrl #(.NUM_BANKS(1), .LINES_IMPL(32), .MAP_SPLIT(1'b0)) dut_flat (
      .clk(clk), .rst_n(rst_n), .ext_lines(fext), .bus_addr(faddr), .bus_wr(fwr),
      .bus_rd(frd), .bus_wdata(fwdata), .bus_rdata(frdata), .irq_out(firq), .evt_out(fevt));

   // split map addresses
   function automatic logic [7:0] a_rise(int b); return 8'(8'h00 + b*32); endfunction
   function automatic logic [7:0] a_fall(int b); return 8'(8'h04 + b*32); endfunction
   function automatic logic [7:0] a_swt (int b); return 8'(8'h08 + b*32); endfunction
   function automatic logic [7:0] a_ien (int b); return 8'(8'h80 + b*16); endfunction
   function automatic logic [7:0] a_een (int b); return 8'(8'h84 + b*16); endfunction
   function automatic logic [7:0] a_pend(int b); return 8'(8'h88 + b*16); endfunction

   // bits: [7] rise [6] fall [5] from [4] to [3] int-en [2] evt-en [1] exp pend [0] exp evt
   localparam logic [7:0] VEC [8] = '{
      8'b1001_1111, 8'b1010_1100, 8'b0110_1010, 8'b0101_1100,
      8'b1101_1111, 8'b1110_0101, 8'b0001_1100, 8'b1110_1010 };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bwr(input logic [7:0] a, input logic [31:0] v);
      @(negedge clk); addr = a; wdata = v; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic brd(input logic [7:0] a, output logic [31:0] v);
      addr = a; rd = 1'b1; #1; v = rdata; rd = 1'b0;
   endtask

   task automatic fwrite(input logic [7:0] a, input logic [31:0] v);
      @(negedge clk); faddr = a; fwdata = v; fwr = 1'b1;
      @(negedge clk); fwr = 1'b0;
   endtask

   task automatic fread(input logic [7:0] a, output logic [31:0] v);
      faddr = a; frd = 1'b1; #1; v = frdata; frd = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // config written during reset; line 0 of bank 0 held high (R10)
      ext[0] = 1'b1;
      for (int b = 0; b < 2; b++) begin
         bwr(a_ien(b), 32'h0); bwr(a_een(b), 32'h0);
         bwr(a_rise(b), 32'h0); bwr(a_fall(b), 32'h0);
      end
      bwr(a_rise(0), 32'h1); bwr(a_ien(0), 32'h1);
      for (int i = 0; i < 4; i++) fwrite(8'(i*4), 32'h0);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk("R1 irq after reset", {30'd0, irq}, 32'h0);
      chk("R1 evt after reset", evt[31:0] | evt[63:32], 32'h0);
      brd(a_pend(1), d); chk("R1 pend after reset", d, 32'h0);
      brd(a_ien(0), d);  chk("R1 config written in reset", d, 32'h1);
      repeat (6) @(negedge clk);
      brd(a_pend(0), d); chk("R10 no edge from level held through reset", d, 32'h0);

      // R8 implemented-line probe
      bwr(a_rise(0), 32'hFFFF_FFFF);
      brd(a_rise(0), d); chk("R8 probe implemented lines", d, 32'h00FF_FFFF);
      bwr(a_rise(0), 32'h0); bwr(a_ien(0), 32'h0);

      // R2/R3/R6 vector table on bank 1 line 5 (global line 37)
      for (int i = 0; i < 8; i++) begin
         logic [7:0] v;
         v = VEC[i];
         bwr(a_rise(1), {26'd0, v[7], 5'd0});
         bwr(a_fall(1), {26'd0, v[6], 5'd0});
         bwr(a_ien(1),  {26'd0, v[3], 5'd0});
         bwr(a_een(1),  {26'd0, v[2], 5'd0});
         @(negedge clk); ext[37] = v[5];
         repeat (5) @(negedge clk);
         bwr(a_pend(1), 32'hFFFF_FFFF);
         @(negedge clk); ext[37] = v[4];
         repeat (3) @(posedge clk);
         #1;
         chk($sformatf("R6 event vec %0d", i), {31'd0, evt[37]}, {31'd0, v[0]});
         brd(a_pend(1), d);
         chk($sformatf("R2 R3 pending vec %0d", i), d, {26'd0, v[1], 5'd0});
         chk($sformatf("R5 irq vec %0d", i), {31'd0, irq[1]}, {31'd0, v[1]});
      end

      // R6 pulse lasts one cycle
      bwr(a_rise(1), 32'h20); bwr(a_een(1), 32'h20); bwr(a_ien(1), 32'h0);
      @(negedge clk); ext[37] = 1'b0;
      repeat (5) @(negedge clk);
      ext[37] = 1'b1;
      repeat (3) @(posedge clk);
      #1; chk("R6 pulse high", {31'd0, evt[37]}, 32'h1);
      @(posedge clk); #1; chk("R6 pulse one cycle", {31'd0, evt[37]}, 32'h0);

      // R7 software trigger
      bwr(a_pend(1), 32'hFFFF_FFFF);
      bwr(a_ien(0), 32'h4);
      bwr(a_swt(0), 32'h4);
      brd(a_pend(0), d); chk("R7 sw sets pending", d, 32'h4);
      brd(a_swt(0), d);  chk("R7 sw reads back", d, 32'h4);
      chk("R5 irq with pending", {31'd0, irq[0]}, 32'h1);
      chk("R5 other bank quiet", {31'd0, irq[1]}, 32'h0);
      bwr(a_swt(0), 32'h8);
      brd(a_pend(0), d); chk("R3 sw on disabled line", d, 32'h4);
      bwr(a_swt(0), 32'h0);
      brd(a_swt(0), d);  chk("R7 sw write zero", d, 32'hC);
      bwr(a_pend(0), 32'h4);
      brd(a_swt(0), d);  chk("R7 sw cleared with pending", d, 32'h8);
      brd(a_pend(0), d); chk("R4 write one clears", d, 32'h0);
      chk("R5 irq drops", {31'd0, irq[0]}, 32'h0);
      bwr(a_pend(0), 32'h8);

      // R4 write zero, then set and clear in one cycle
      bwr(a_ien(0), 32'h6); bwr(a_rise(0), 32'h2);
      bwr(a_swt(0), 32'h6);
      bwr(a_pend(0), 32'h0);
      brd(a_pend(0), d); chk("R4 write zero no effect", d, 32'h6);
      @(negedge clk); ext[1] = 1'b1;
      @(negedge clk);
      @(negedge clk); addr = a_pend(0); wdata = 32'h2; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
      brd(a_pend(0), d); chk("R4 edge wins over clear", d, 32'h6);
      brd(a_swt(0), d);  chk("R7 sw bit cleared by pending clear", d, 32'h4);
      bwr(a_pend(0), 32'h2);
      chk("R5 irq held by remaining bit", {31'd0, irq[0]}, 32'h1);
      bwr(a_pend(0), 32'h4);
      chk("R5 irq low when all clear", {31'd0, irq[0]}, 32'h0);

      // R1 soft reset keeps config, clears pending
      bwr(a_rise(0), 32'hF0);
      bwr(a_swt(0), 32'h4);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      #1;
      brd(a_rise(0), d); chk("R1 config kept over reset", d, 32'hF0);
      brd(a_pend(0), d); chk("R1 pending cleared by reset", d, 32'h0);
      brd(a_swt(0), d);  chk("R1 sw cleared by reset", d, 32'h0);

      // R9 address map
      bwr(8'h60, 32'hFFFF_FFFF);
      brd(8'h60, d); chk("R9 absent bank reads zero", d, 32'h0);
      brd(8'h0C, d); chk("R9 unmapped split reads zero", d, 32'h0);
      brd(8'h81, d); chk("R9 misaligned reads zero", d, 32'h0);
      addr = a_rise(0); rd = 1'b0; #1;
      chk("R9 rdata zero without strobe", rdata, 32'h0);
      fwrite(8'h08, 32'h1234);
      fread(8'h08, d); chk("R9 flat rising select", d, 32'h1234);
      fwrite(8'h00, 32'h1);
      fwrite(8'h10, 32'h1);
      fread(8'h14, d); chk("R9 flat pending", d, 32'h1);
      fread(8'h10, d); chk("R9 flat sw trigger", d, 32'h1);
      fread(8'h18, d); chk("R9 flat unmapped", d, 32'h0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule